// File: doc/BRIEF.md
# USB Controller Bring-Up Sequencer

This block walks a dual-role USB controller wrapper through its power-on order after one pulse on `start_i`. It drives the wrapper's control fields directly. First it holds every reset. Next it sets up the controller clock divider and then the reference clock, the spread-spectrum clock and the PHY power. After that it releases the wrapper reset and then the host-core reset, with a fixed wait after each release. It then turns on the interface clock, selects host mode and sets the endian fields. The PHY reset is released last.

At the start pulse the block latches a reference-rate code, a reference-source select, the port-power options and the endian choice. It derives the PLL multiplier and the frequency-select code from the latched rate and source. It does not model the PHY analog behaviour or the host core. `done_o` reports that the sequence has completed. `err_o` reports that an unsupported rate code was replaced by the 100 MHz setting.

Top module: `usbc_bringup_seq`

## Requirements
- R1: After reset every output is 0, except `dev_mode_o`, which is 1.
- R2: When `start_i` is sampled high in idle, the next clock edge raises `phy_rst_o`, `host_rst_o` and `wrap_rst_o` together and clears `done_o` and `err_o`.
- R3: The divider steps take one edge each, in this order. `div_rst_o` rises. Then `div_sel_o` and `hclk_en_o` are written. Then `div_rst_o` falls. `div_sel_o` is the lowest index into the ratio list {1,2,4,6,8,16,24,32} for which CORE_CLK_MHZ divided by that ratio lies within [HCLK_MIN_MHZ, HCLK_MAX_MHZ], or 7 if no index fits. With the default parameters `div_sel_o` is 2.
- R4: Rate code 0 means 100 MHz, 1 means 50 MHz and 2 means 125 MHz. These give `mpll_mul_o` values of 0x19, 0x32 and 0x28. Rate code 3 falls back to 0x19 and sets `err_o`.
- R5: `fsel_o` is 0x27 when the latched source select is 0 or 1 and the effective rate is 100 MHz. In every other case it is 0x07. `div2_o` is 0, and `ref_src_o` takes the latched source select.
- R6: On the edge after the divider reset falls, `ssc_en_o`, `ssp_ref_en_o`, `hs_pwr_o` and `ss_pwr_o` are all set, and the reference fields of R4 and R5 are written on that same edge.
- R7: `wrap_rst_o` falls WAIT_CYC+1 edges after the power-up edge. `host_rst_o` falls WAIT_CYC+2 edges after `wrap_rst_o` falls.
- R8: The port-power fields are written WAIT_CYC+1 edges after the wrapper release. `pp_en_o` equals the latched power-present input. `pp_high_o` is 1 only when power is present and active-low was not requested.
- R9: WAIT_CYC+1 edges after the host-core release, `ifclk_en_o` is set. On the next edge `dev_mode_o` is cleared to 0, which selects host mode.
- R10: On the edge after host mode is selected, `dma_endian_o` and `csr_endian_o` both become 1 for big-endian and 0 otherwise. On the edge after that, `phy_rst_o` falls and `done_o` rises together. `done_o` then stays high until the next accepted start.
- R11: A start pulse while a sequence is running is ignored and does not change the timing.
- R12: Input values are used only as latched at the accepted start. Changes while a sequence is running have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, acted on only when idle |
| rate_code_i | input | 2 | Reference rate: 0=100 MHz, 1=50 MHz, 2=125 MHz, 3=unsupported |
| ref_src_i | input | 2 | Reference-source select |
| pwr_present_i | input | 1 | A port-power pin is configured |
| pwr_active_low_i | input | 1 | Port power is active-low |
| big_endian_i | input | 1 | Select big-endian DMA and register access |
| phy_rst_o | output | 1 | PHY reset |
| host_rst_o | output | 1 | Host-core reset |
| wrap_rst_o | output | 1 | Wrapper reset |
| div_rst_o | output | 1 | Controller clock divider reset |
| hclk_en_o | output | 1 | Controller clock enable |
| div_sel_o | output | 3 | Divider ratio index |
| ref_src_o | output | 2 | Reference-source field |
| fsel_o | output | 6 | Reference frequency-select code |
| div2_o | output | 1 | Reference divide-by-2 |
| mpll_mul_o | output | 7 | PLL multiplier |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssp_ref_en_o | output | 1 | SuperSpeed reference enable |
| hs_pwr_o | output | 1 | HighSpeed PHY power |
| ss_pwr_o | output | 1 | SuperSpeed PHY power |
| ifclk_en_o | output | 1 | Interface clock enable |
| dev_mode_o | output | 1 | Role: 1=device, 0=host |
| pp_en_o | output | 1 | Port-power control enable |
| pp_high_o | output | 1 | Port-power polarity, 1=active-high |
| dma_endian_o | output | 2 | DMA endian mode |
| csr_endian_o | output | 2 | Register access endian mode |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Unsupported rate replaced by the 100 MHz setting |

## Verification
The hardest case to produce from the ports is a second start pulse together with changed inputs arriving partway through a running sequence. It is only visible if every later edge keeps the timing and the field values of the first request. The random runs therefore pick a disturbance cycle anywhere from the second edge up to the edge before completion. At that cycle they pulse start and scramble all inputs, then check each field against the values latched at the original start. Directed runs cover all 16 combinations of rate code and source select, including the unsupported rate code with both source groups.

// File: rtl/usbc_bringup_pkg.sv
package usbc_bringup_pkg;

    localparam int DIV_SEL_W = 3;
    localparam int SRC_W     = 2;
    localparam int FSEL_W    = 6;
    localparam int MPLL_W    = 7;
    localparam int ENDIAN_W  = 2;
    localparam int RATE_W    = 2;

    localparam logic [RATE_W-1:0] RATE_100 = 2'd0;
    localparam logic [RATE_W-1:0] RATE_50  = 2'd1;
    localparam logic [RATE_W-1:0] RATE_125 = 2'd2;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_DIV_RST,
        ST_DIV_CFG,
        ST_DIV_REL,
        ST_REFCLK,
        ST_WAIT_PWR,
        ST_REL_WRAP,
        ST_WAIT_WRAP,
        ST_PORT_PWR,
        ST_REL_HOST,
        ST_WAIT_HOST,
        ST_IFCLK,
        ST_HOST_MODE,
        ST_ENDIAN,
        ST_REL_PHY
    } seq_state_e;

    typedef struct packed {
        logic                 phy_rst;
        logic                 host_rst;
        logic                 wrap_rst;
        logic                 div_rst;
        logic                 hclk_en;
        logic [DIV_SEL_W-1:0] div_sel;
        logic [SRC_W-1:0]     ref_src;
        logic [FSEL_W-1:0]    fsel;
        logic                 div2;
        logic [MPLL_W-1:0]    mpll;
        logic                 ssc_en;
        logic                 ssp_ref_en;
        logic                 hs_pwr;
        logic                 ss_pwr;
        logic                 ifclk_en;
        logic                 dev_mode;
        logic                 pp_en;
        logic                 pp_high;
        logic [ENDIAN_W-1:0]  dma_endian;
        logic [ENDIAN_W-1:0]  csr_endian;
    } ctl_fields_t;

    typedef struct packed {
        logic [RATE_W-1:0] rate_code;
        logic [SRC_W-1:0]  ref_src;
        logic              pwr_present;
        logic              pwr_active_low;
        logic              big_endian;
    } start_cfg_t;

    typedef struct packed {
        seq_state_e  state;
        ctl_fields_t ctl;
        start_cfg_t  cfg;
        logic        done;
        logic        err;
    } seq_regs_t;

    function automatic int hdiv_ratio(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            4:       return 8;
            5:       return 16;
            6:       return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [DIV_SEL_W-1:0] pick_hdiv(input int core_mhz,
                                                        input int lo_mhz,
                                                        input int hi_mhz);
        logic [DIV_SEL_W-1:0] sel;
        sel = 3'd7;
        for (int i = 7; i >= 0; i--) begin
            if ((core_mhz / hdiv_ratio(i)) >= lo_mhz &&
                (core_mhz / hdiv_ratio(i)) <= hi_mhz) begin
                sel = DIV_SEL_W'(i);
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/usbc_refclk_decode.sv
module usbc_refclk_decode
    import usbc_bringup_pkg::*;
(
    input  logic [RATE_W-1:0] rate_code_i,
    input  logic [SRC_W-1:0]  ref_src_i,
    output logic [MPLL_W-1:0] mpll_o,
    output logic [FSEL_W-1:0] fsel_o,
    output logic              bad_rate_o
);

    logic is_100;

    always_comb begin
        bad_rate_o = 1'b0;
        case (rate_code_i)
            RATE_100: mpll_o = 7'h19;
            RATE_50:  mpll_o = 7'h32;
            RATE_125: mpll_o = 7'h28;
            default: begin
                mpll_o     = 7'h19;
                bad_rate_o = 1'b1;
            end
        endcase
        is_100 = (rate_code_i == RATE_100) || bad_rate_o;
        fsel_o = (is_100 && !ref_src_i[1]) ? 6'h27 : 6'h07;
    end

endmodule

// File: rtl/usbc_portpwr_map.sv
module usbc_portpwr_map (
    input  logic present_i,
    input  logic active_low_i,
    output logic pp_en_o,
    output logic pp_high_o
);

    always_comb begin
        pp_en_o   = present_i;
        pp_high_o = present_i && !active_low_i;
    end

endmodule

// File: rtl/usbc_wait_timer.sv
module usbc_wait_timer #(
    parameter int WAIT_CYC = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = run_i && (cnt_q == LAST);
        cnt_d     = (run_i && !expired_o) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/usbc_bringup_seq.sv
module usbc_bringup_seq
    import usbc_bringup_pkg::*;
#(
    parameter int WAIT_CYC     = 10,
    parameter int CORE_CLK_MHZ = 800,
    parameter int HCLK_MIN_MHZ = 150,
    parameter int HCLK_MAX_MHZ = 300
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [RATE_W-1:0]    rate_code_i,
    input  logic [SRC_W-1:0]     ref_src_i,
    input  logic                 pwr_present_i,
    input  logic                 pwr_active_low_i,
    input  logic                 big_endian_i,
    output logic                 phy_rst_o,
    output logic                 host_rst_o,
    output logic                 wrap_rst_o,
    output logic                 div_rst_o,
    output logic                 hclk_en_o,
    output logic [DIV_SEL_W-1:0] div_sel_o,
    output logic [SRC_W-1:0]     ref_src_o,
    output logic [FSEL_W-1:0]    fsel_o,
    output logic                 div2_o,
    output logic [MPLL_W-1:0]    mpll_mul_o,
    output logic                 ssc_en_o,
    output logic                 ssp_ref_en_o,
    output logic                 hs_pwr_o,
    output logic                 ss_pwr_o,
    output logic                 ifclk_en_o,
    output logic                 dev_mode_o,
    output logic                 pp_en_o,
    output logic                 pp_high_o,
    output logic [ENDIAN_W-1:0]  dma_endian_o,
    output logic [ENDIAN_W-1:0]  csr_endian_o,
    output logic                 done_o,
    output logic                 err_o
);

    localparam logic [DIV_SEL_W-1:0] HDIV_SEL =
        pick_hdiv(CORE_CLK_MHZ, HCLK_MIN_MHZ, HCLK_MAX_MHZ);

    seq_regs_t seq_d, seq_q;

    logic [MPLL_W-1:0] dec_mpll;
    logic [FSEL_W-1:0] dec_fsel;
    logic              dec_bad;
    logic              map_pp_en;
    logic              map_pp_high;
    logic              tmr_run;
    logic              tmr_expired;

    usbc_refclk_decode u_refclk (
        .rate_code_i (seq_q.cfg.rate_code),
        .ref_src_i   (seq_q.cfg.ref_src),
        .mpll_o      (dec_mpll),
        .fsel_o      (dec_fsel),
        .bad_rate_o  (dec_bad)
    );

    usbc_portpwr_map u_ppmap (
        .present_i    (seq_q.cfg.pwr_present),
        .active_low_i (seq_q.cfg.pwr_active_low),
        .pp_en_o      (map_pp_en),
        .pp_high_o    (map_pp_high)
    );

    assign tmr_run = (seq_q.state == ST_WAIT_PWR)  ||
                     (seq_q.state == ST_WAIT_WRAP) ||
                     (seq_q.state == ST_WAIT_HOST);

    usbc_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (tmr_run),
        .expired_o (tmr_expired)
    );

    function automatic seq_regs_t reset_value();
        seq_regs_t r;
        r              = '0;
        r.state        = ST_IDLE;
        r.ctl.dev_mode = 1'b1;
        return r;
    endfunction

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.cfg.rate_code      = rate_code_i;
                    seq_d.cfg.ref_src        = ref_src_i;
                    seq_d.cfg.pwr_present    = pwr_present_i;
                    seq_d.cfg.pwr_active_low = pwr_active_low_i;
                    seq_d.cfg.big_endian     = big_endian_i;
                    seq_d.ctl.phy_rst        = 1'b1;
                    seq_d.ctl.host_rst       = 1'b1;
                    seq_d.ctl.wrap_rst       = 1'b1;
                    seq_d.done               = 1'b0;
                    seq_d.err                = 1'b0;
                    seq_d.state              = ST_DIV_RST;
                end
            end
            ST_DIV_RST: begin
                seq_d.ctl.div_rst = 1'b1;
                seq_d.state       = ST_DIV_CFG;
            end
            ST_DIV_CFG: begin
                seq_d.ctl.div_sel = HDIV_SEL;
                seq_d.ctl.hclk_en = 1'b1;
                seq_d.state       = ST_DIV_REL;
            end
            ST_DIV_REL: begin
                seq_d.ctl.div_rst = 1'b0;
                seq_d.state       = ST_REFCLK;
            end
            ST_REFCLK: begin
                seq_d.ctl.ref_src    = seq_q.cfg.ref_src;
                seq_d.ctl.fsel       = dec_fsel;
                seq_d.ctl.div2       = 1'b0;
                seq_d.ctl.mpll       = dec_mpll;
                seq_d.ctl.ssc_en     = 1'b1;
                seq_d.ctl.ssp_ref_en = 1'b1;
                seq_d.ctl.hs_pwr     = 1'b1;
                seq_d.ctl.ss_pwr     = 1'b1;
                seq_d.err            = dec_bad;
                seq_d.state          = ST_WAIT_PWR;
            end
            ST_WAIT_PWR: begin
                if (tmr_expired) seq_d.state = ST_REL_WRAP;
            end
            ST_REL_WRAP: begin
                seq_d.ctl.wrap_rst = 1'b0;
                seq_d.state        = ST_WAIT_WRAP;
            end
            ST_WAIT_WRAP: begin
                if (tmr_expired) seq_d.state = ST_PORT_PWR;
            end
            ST_PORT_PWR: begin
                seq_d.ctl.pp_en   = map_pp_en;
                seq_d.ctl.pp_high = map_pp_high;
                seq_d.state       = ST_REL_HOST;
            end
            ST_REL_HOST: begin
                seq_d.ctl.host_rst = 1'b0;
                seq_d.state        = ST_WAIT_HOST;
            end
            ST_WAIT_HOST: begin
                if (tmr_expired) seq_d.state = ST_IFCLK;
            end
            ST_IFCLK: begin
                seq_d.ctl.ifclk_en = 1'b1;
                seq_d.state        = ST_HOST_MODE;
            end
            ST_HOST_MODE: begin
                seq_d.ctl.dev_mode = 1'b0;
                seq_d.state        = ST_ENDIAN;
            end
            ST_ENDIAN: begin
                seq_d.ctl.dma_endian = {1'b0, seq_q.cfg.big_endian};
                seq_d.ctl.csr_endian = {1'b0, seq_q.cfg.big_endian};
                seq_d.state          = ST_REL_PHY;
            end
            ST_REL_PHY: begin
                seq_d.ctl.phy_rst = 1'b0;
                seq_d.done        = 1'b1;
                seq_d.state       = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= reset_value();
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phy_rst_o    = seq_q.ctl.phy_rst;
    assign host_rst_o   = seq_q.ctl.host_rst;
    assign wrap_rst_o   = seq_q.ctl.wrap_rst;
    assign div_rst_o    = seq_q.ctl.div_rst;
    assign hclk_en_o    = seq_q.ctl.hclk_en;
    assign div_sel_o    = seq_q.ctl.div_sel;
    assign ref_src_o    = seq_q.ctl.ref_src;
    assign fsel_o       = seq_q.ctl.fsel;
    assign div2_o       = seq_q.ctl.div2;
    assign mpll_mul_o   = seq_q.ctl.mpll;
    assign ssc_en_o     = seq_q.ctl.ssc_en;
    assign ssp_ref_en_o = seq_q.ctl.ssp_ref_en;
    assign hs_pwr_o     = seq_q.ctl.hs_pwr;
    assign ss_pwr_o     = seq_q.ctl.ss_pwr;
    assign ifclk_en_o   = seq_q.ctl.ifclk_en;
    assign dev_mode_o   = seq_q.ctl.dev_mode;
    assign pp_en_o      = seq_q.ctl.pp_en;
    assign pp_high_o    = seq_q.ctl.pp_high;
    assign dma_endian_o = seq_q.ctl.dma_endian;
    assign csr_endian_o = seq_q.ctl.csr_endian;
    assign done_o       = seq_q.done;
    assign err_o        = seq_q.err;

endmodule

// File: rtl/usbc_bringup_chk.sv
module usbc_bringup_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       phy_rst_o,
    input logic       host_rst_o,
    input logic       wrap_rst_o,
    input logic       div_rst_o,
    input logic       hclk_en_o,
    input logic [6:0] mpll_mul_o,
    input logic       ssc_en_o,
    input logic       ssp_ref_en_o,
    input logic       hs_pwr_o,
    input logic       ss_pwr_o,
    input logic       ifclk_en_o,
    input logic       dev_mode_o,
    input logic       pp_en_o,
    input logic       pp_high_o,
    input logic       done_o,
    input logic       err_o
);

    assert_resets_together_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_rst_o) |-> (phy_rst_o && wrap_rst_o));

    assert_div_release_clocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(div_rst_o) |-> hclk_en_o);

    assert_fallback_mult_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (mpll_mul_o == 7'h19));

    assert_power_same_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_pwr_o) |-> (ss_pwr_o && ssc_en_o && ssp_ref_en_o && !div_rst_o));

    assert_wrap_after_power_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wrap_rst_o) |-> (hs_pwr_o && ss_pwr_o && host_rst_o));

    assert_host_after_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(host_rst_o) |-> !wrap_rst_o);

    assert_polarity_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pp_high_o |-> pp_en_o);

    assert_host_mode_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dev_mode_o) |-> (ifclk_en_o && !host_rst_o));

    assert_phy_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> ($fell(phy_rst_o) && !host_rst_o && !wrap_rst_o && !dev_mode_o));

    assert_done_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !phy_rst_o) |=> (done_o || phy_rst_o));

endmodule

bind usbc_bringup_seq usbc_bringup_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phy_rst_o    (phy_rst_o),
    .host_rst_o   (host_rst_o),
    .wrap_rst_o   (wrap_rst_o),
    .div_rst_o    (div_rst_o),
    .hclk_en_o    (hclk_en_o),
    .mpll_mul_o   (mpll_mul_o),
    .ssc_en_o     (ssc_en_o),
    .ssp_ref_en_o (ssp_ref_en_o),
    .hs_pwr_o     (hs_pwr_o),
    .ss_pwr_o     (ss_pwr_o),
    .ifclk_en_o   (ifclk_en_o),
    .dev_mode_o   (dev_mode_o),
    .pp_en_o      (pp_en_o),
    .pp_high_o    (pp_high_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/tb_usbc_bringup_seq.sv
module tb_usbc_bringup_seq;

    localparam int W    = 10;
    localparam int N_PWR  = 5;
    localparam int N_WRAP = N_PWR + W + 1;
    localparam int N_PP   = N_WRAP + W + 1;
    localparam int N_HOST = N_PP + 1;
    localparam int N_IFC  = N_HOST + W + 1;
    localparam int N_MODE = N_IFC + 1;
    localparam int N_END  = N_MODE + 1;
    localparam int N_DONE = N_END + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] rate_code = '0;
    logic [1:0] ref_src = '0;
    logic       pwr_present = 1'b0;
    logic       pwr_active_low = 1'b0;
    logic       big_endian = 1'b0;

    logic       phy_rst, host_rst, wrap_rst, div_rst, hclk_en;
    logic [2:0] div_sel;
    logic [1:0] ref_src_q;
    logic [5:0] fsel;
    logic       div2;
    logic [6:0] mpll;
    logic       ssc_en, ssp_ref_en, hs_pwr, ss_pwr, ifclk_en, dev_mode;
    logic       pp_en, pp_high;
    logic [1:0] dma_endian, csr_endian;
    logic       done, err;

    int  nvec = 0;
    int  nfail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    usbc_bringup_seq dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .start_i          (start),
        .rate_code_i      (rate_code),
        .ref_src_i        (ref_src),
        .pwr_present_i    (pwr_present),
        .pwr_active_low_i (pwr_active_low),
        .big_endian_i     (big_endian),
        .phy_rst_o        (phy_rst),
        .host_rst_o       (host_rst),
        .wrap_rst_o       (wrap_rst),
        .div_rst_o        (div_rst),
        .hclk_en_o        (hclk_en),
        .div_sel_o        (div_sel),
        .ref_src_o        (ref_src_q),
        .fsel_o           (fsel),
        .div2_o           (div2),
        .mpll_mul_o       (mpll),
        .ssc_en_o         (ssc_en),
        .ssp_ref_en_o     (ssp_ref_en),
        .hs_pwr_o         (hs_pwr),
        .ss_pwr_o         (ss_pwr),
        .ifclk_en_o       (ifclk_en),
        .dev_mode_o       (dev_mode),
        .pp_en_o          (pp_en),
        .pp_high_o        (pp_high),
        .dma_endian_o     (dma_endian),
        .csr_endian_o     (csr_endian),
        .done_o           (done),
        .err_o            (err)
    );

    function automatic int exp_mpll(input int rc);
        case (rc)
            1:       return 'h32;
            2:       return 'h28;
            default: return 'h19;
        endcase
    endfunction

    function automatic int exp_fsel(input int rc, input int src);
        return (((rc == 0) || (rc == 3)) && (src < 2)) ? 'h27 : 'h07;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    task automatic run_seq(input int rc, input int src, input bit pp, input bit al,
                           input bit be, input int disturb_n);
        @(negedge clk);
        rate_code      = 2'(rc);
        ref_src        = 2'(src);
        pwr_present    = pp;
        pwr_active_low = al;
        big_endian     = be;
        start          = 1'b1;
        for (int n = 1; n <= N_DONE; n++) begin
            @(negedge clk);
            chk("R2 phy_rst", int'(phy_rst), int'(n < N_DONE));
            chk("R7 wrap_rst", int'(wrap_rst), int'(n < N_WRAP));
            chk("R7 host_rst", int'(host_rst), int'(n < N_HOST));
            chk("R3 div_rst", int'(div_rst), int'(n == 2 || n == 3));
            chk("R10 done", int'(done), int'(n >= N_DONE));
            if (n < N_PWR) chk("R2 err cleared", int'(err), 0);
            if (n >= N_PWR) begin
                chk("R6 power", int'({hs_pwr, ss_pwr, ssc_en, ssp_ref_en}), 'hF);
                chk("R4 mpll", int'(mpll), exp_mpll(rc));
                chk("R4 err", int'(err), int'(rc == 3));
                chk("R5 fsel", int'(fsel), exp_fsel(rc, src));
                chk("R5 div2/src", int'({div2, ref_src_q}), src);
            end
            if (n >= 3) chk("R3 div_sel/hclk_en", int'({hclk_en, div_sel}), 'hA);
            if (n >= N_PP) chk("R8 port power", int'({pp_en, pp_high}),
                               int'({pp, pp && !al}));
            if (n >= N_IFC) chk("R9 ifclk", int'(ifclk_en), 1);
            if (n >= N_MODE) chk("R9 host mode", int'(dev_mode), 0);
            if (n >= N_END) chk("R10 endian", int'({dma_endian, csr_endian}),
                                int'({1'b0, be, 1'b0, be}));
            // R11 / R12: stray start and scrambled inputs mid-run
            start = (n == disturb_n) && (n < N_DONE);
            if (n == disturb_n) begin
                rate_code      = 2'($urandom);
                ref_src        = 2'($urandom);
                pwr_present    = 1'($urandom);
                pwr_active_low = 1'($urandom);
                big_endian     = 1'($urandom);
            end
        end
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 done held", int'({done, phy_rst}), 2);
            chk("R11 no restart", int'(host_rst), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values while held in reset and just after release
        chk("R1 reset outputs", int'({phy_rst, host_rst, wrap_rst, div_rst, hclk_en,
                                      ssc_en, hs_pwr, ifclk_en, pp_en, done, err}), 0);
        chk("R1 reset fields", int'({div_sel, mpll, fsel, dma_endian}), 0);
        chk("R1 dev_mode", int'(dev_mode), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'({phy_rst, dev_mode, done}), 'b010);
        // R4 R5: every rate code with every source select
        for (int rc = 0; rc < 4; rc++) begin
            for (int src = 0; src < 4; src++) begin
                run_seq(rc, src, rc[0], src[0], src[1], 0);
            end
        end
        // R11 R12: random requests with a disturbance anywhere in the run
        for (int i = 0; i < 14; i++) begin
            run_seq(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                    1'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom_range(N_DONE - 1, 2)));
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R10 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule